// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Table Index

The block gathers interrupt requests from a group of peripherals and presents them to a processor that has a single interrupt input. When at least one request is pending and not masked, the block picks one of them and raises the processor interrupt. It then holds a short table index for the chosen source, and the processor reads it over a small register port. Software uses this index to find the service routine address in a jump table held in memory. The index is not a full address, so it stays narrow, and a service routine can move without any change to the peripheral.

Two priority schemes are available. In fixed mode, source 0 always ranks highest. In rotating mode, the source whose service ended most recently drops to the lowest rank. The winner stays frozen until software writes the end-of-service register. When software reads the index, the chosen peripheral receives a one-cycle acknowledge, so it can clear its request.

Top module: `irq_vector_arbiter`

## Requirements
- R1: After reset: `int_o` is low, `ack_o` is zero, fixed mode is selected, the mask is zero, and index register i holds i+1.
- R2: While `int_o` is low, an unmasked pending request at a rising edge makes `int_o` high from that edge on. `int_o` never rises without one.
- R3: With config bit 0 = 0 (fixed mode), the winner is the lowest-numbered unmasked pending source.
- R4: With config bit 0 = 1 (rotating mode), the search starts at the source after the last served source and wraps around. Every end-of-service in either mode records the winner as last served. After reset, last served is N_SRC-1.
- R5: Mask register bit i = 1 (address 2) hides source i. If every pending source is masked, `int_o` stays low.
- R6: Address 0 reads the winner's table index while `int_o` is high and reads zero while it is low. Writes to address 0 have no effect.
- R7: While `int_o` is high, the winner does not change, even if a higher-ranked request arrives.
- R8: A write to address 3 while `int_o` is high drops `int_o` at that edge. Arbitration resumes one cycle later. The same write while `int_o` is low has no effect.
- R9: A read of address 0 while `int_o` is high sets the winner's `ack_o` bit, and only that bit, for exactly the next cycle. Any other read gives no acknowledge.
- R10: Addresses 4+i hold the 8-bit table index of source i and can be read and written. Address 1 bit 0 is the mode bit; address 2 is the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_SRC | Request lines, one per peripheral |
| ack_o | output | N_SRC | One-cycle acknowledge to the granted peripheral |
| int_o | output | 1 | Interrupt to the processor |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (used only to generate the acknowledge) |
| bus_wdata | input | IDX_W | Write data |
| bus_rdata | output | IDX_W | Read data for `bus_addr`, same cycle |

## Verification
The assertions check several rules on every cycle. The acknowledge is one-hot, and it follows only an index read made while the interrupt is high. The winner holds still while the interrupt stays up. An end-of-service write drops the interrupt, and the index reads zero while idle. The interrupt never rises without an unmasked request, and in fixed mode a rising interrupt always picks the lowest pending source. Other behaviour can only be shown by the bench's scenarios: the exact rotating order after each possible last-served source, how the mask covers all request patterns, how history carries across a mode change, and the writes that must have no effect.

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter #(
  parameter int N_SRC  = 4,
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  req_i,
  output logic [N_SRC-1:0]  ack_o,
  output logic              int_o,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [IDX_W-1:0]  bus_wdata,
  output logic [IDX_W-1:0]  bus_rdata
);
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [ADDR_W-1:0] A_INDEX = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_EOS   = ADDR_W'(3);
  localparam int A_VEC0 = 4;

  logic             rot_q, active_q;
  logic [N_SRC-1:0] mask_q, ack_q, pend;
  logic [SRC_W-1:0] win_q, last_q, pick;
  logic [IDX_W-1:0] vec_q [N_SRC];
  logic             found;
  logic [SRC_W:0]   cand;

  assign pend  = req_i & ~mask_q;
  assign int_o = active_q;
  assign ack_o = ack_q;

  wire rd_index = bus_rd && (bus_addr == A_INDEX);
  wire eos_hit  = bus_wr && (bus_addr == A_EOS);

  always_comb begin
    found = 1'b0;
    pick  = '0;
    cand  = '0;
    for (int k = 1; k <= N_SRC; k++) begin
      cand = rot_q ? ({1'b0, last_q} + (SRC_W+1)'(k)) : (SRC_W+1)'(k - 1);
      if (cand >= (SRC_W+1)'(N_SRC)) cand = cand - (SRC_W+1)'(N_SRC);
      if (!found && pend[cand[SRC_W-1:0]]) begin
        found = 1'b1;
        pick  = cand[SRC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      win_q    <= '0;
      last_q   <= SRC_W'(N_SRC - 1);
      ack_q    <= '0;
    end else begin
      ack_q <= (rd_index && active_q) ? (N_SRC'(1) << win_q) : '0;
      if (active_q) begin
        if (eos_hit) begin
          active_q <= 1'b0;
          last_q   <= win_q;
        end
      end else if (found) begin
        active_q <= 1'b1;
        win_q    <= pick;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_q  <= 1'b0;
      mask_q <= '0;
      for (int i = 0; i < N_SRC; i++) vec_q[i] <= IDX_W'(i + 1);
    end else if (bus_wr) begin
      if (bus_addr == A_CFG)  rot_q  <= bus_wdata[0];
      if (bus_addr == A_MASK) mask_q <= bus_wdata[N_SRC-1:0];
      for (int i = 0; i < N_SRC; i++)
        if (bus_addr == ADDR_W'(A_VEC0 + i)) vec_q[i] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_INDEX)     bus_rdata = active_q ? vec_q[win_q] : '0;
    else if (bus_addr == A_CFG)  bus_rdata = IDX_W'(rot_q);
    else if (bus_addr == A_MASK) bus_rdata = IDX_W'(mask_q);
    else
      for (int i = 0; i < N_SRC; i++)
        if (bus_addr == ADDR_W'(A_VEC0 + i)) bus_rdata = vec_q[i];
  end
endmodule

// File: rtl/irq_vector_arbiter_chk.sv
module irq_vector_arbiter_chk #(
  parameter int N_SRC  = 4,
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 4,
  parameter int SRC_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  req_i,
  input logic [N_SRC-1:0]  ack_o,
  input logic              int_o,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [IDX_W-1:0]  bus_rdata,
  input logic [N_SRC-1:0]  mask_q,
  input logic              rot_q,
  input logic [SRC_W-1:0]  win_q
);
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ack_o)); // R9
  AST_ACK_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_o) |-> $past(bus_rd && bus_addr == ADDR_W'(0) && int_o)); // R9
  AST_WIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (int_o && $past(int_o)) |-> $stable(win_q)); // R7
  AST_EOS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(3) && int_o) |=> !int_o); // R8
  AST_IDLE_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_o && bus_addr == ADDR_W'(0)) |-> bus_rdata == '0); // R6
  AST_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_o) |-> $past(|(req_i & ~mask_q))); // R2
  AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(int_o) && !$past(rot_q)) |->
      (($past(req_i & ~mask_q) & ((N_SRC'(1) << win_q) - N_SRC'(1))) == '0)); // R3
endmodule

bind irq_vector_arbiter irq_vector_arbiter_chk #(
  .N_SRC(N_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .SRC_W(SRC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_o(ack_o), .int_o(int_o),
  .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .mask_q(mask_q), .rot_q(rot_q), .win_q(win_q)
);

// File: tb/irq_vector_arbiter_tb.sv
`timescale 1ns/1ps
module irq_vector_arbiter_tb;
  localparam int N = 4;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] ack;
  logic       irq;
  logic [3:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  int n_chk = 0, n_fail = 0;
  int last_m = N - 1;
  bit done = 0;

  always #2 clk = ~clk;

  irq_vector_arbiter #(.N_SRC(N), .IDX_W(8), .ADDR_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ack_o(ack), .int_o(irq),
    .bus_addr(addr), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata));

  function automatic logic [7:0] vec(int i); return 8'h13 + 8'(i * 16); endfunction
  function automatic int fix_win(logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return i;
    return -1;
  endfunction
  function automatic int rot_win(logic [N-1:0] p, int last);
    for (int k = 1; k <= N; k++) if (p[(last + k) % N]) return (last + k) % N;
    return -1;
  endfunction

  task automatic tick(); @(negedge clk); endtask
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask
  task automatic bwr(logic [3:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1; tick(); wr = 1'b0;
  endtask
  task automatic brd(logic [3:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1; #1 d = rdata; tick(); rd = 1'b0;
  endtask

  task automatic serve(logic [N-1:0] pat, int w, string tag);
    logic [7:0] d;
    req = pat; tick();
    chk({tag, " R2 int"}, irq, 1);
    brd(4'd0, d);
    chk({tag, " R6 index"}, d, vec(w));
    chk({tag, " R9 ack"}, ack, N'(1) << w);
    tick();
    chk({tag, " R9 ack one cycle"}, ack, 0);
    req = '0;
    bwr(4'd3, 8'd0);
    chk({tag, " R8 int drop"}, irq, 0);
    last_m = w;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 int", irq, 0);
    chk("R1 ack", ack, 0);
    brd(4'd0, d); chk("R1 index zero", d, 0);
    chk("R9 no ack idle read", ack, 0);
    brd(4'd1, d); chk("R1 cfg", d, 0);
    brd(4'd2, d); chk("R1 mask", d, 0);
    for (int i = 0; i < N; i++) begin
      brd(4'(4 + i), d); chk("R1 R10 vec reset", d, i + 1);
      bwr(4'(4 + i), vec(i));
      brd(4'(4 + i), d); chk("R10 vec write", d, vec(i));
    end

    for (int p = 1; p < 16; p++) serve(N'(p), fix_win(N'(p)), "R3 fixed");

    bwr(4'd1, 8'd1);
    brd(4'd1, d); chk("R10 cfg", d, 1);
    for (int l = 0; l < N; l++)
      for (int p = 1; p < 16; p++) begin
        serve(N'(1) << l, l, "R4 prime");
        serve(N'(p), rot_win(N'(p), last_m), "R4 rotate");
      end

    bwr(4'd1, 8'd0);
    serve(4'hF, 0, "R4 fixed after rotate");
    bwr(4'd1, 8'd1);
    serve(4'hF, rot_win(4'hF, last_m), "R4 history across modes");
    bwr(4'd1, 8'd0);

    for (int m = 0; m < 16; m++) begin
      bwr(4'd2, 8'(m));
      if (m == 15) begin
        req = 4'hF; tick(); tick(); tick();
        chk("R5 all masked", irq, 0);
        brd(4'd0, d); chk("R5 R6 idle index", d, 0);
        req = '0;
      end else serve(4'hF, fix_win(~N'(m)), "R5 mask");
    end
    bwr(4'd2, 8'd0);

    req = 4'b0100; tick();
    chk("R7 int", irq, 1);
    req = 4'b0101; tick(); tick();
    brd(4'd0, d); chk("R7 frozen", d, vec(2));
    bwr(4'd0, 8'hFF);
    brd(4'd0, d); chk("R6 index write ignored", d, vec(2));
    brd(4'd1, d); tick();
    chk("R9 other read no ack", ack, 0);
    bwr(4'd3, 8'd0);
    chk("R8 drop", irq, 0);
    tick();
    chk("R8 rearbitrate", irq, 1);
    brd(4'd0, d); chk("R8 new winner", d, vec(0));
    req = '0; bwr(4'd3, 8'd0);
    bwr(4'd3, 8'd0);
    chk("R8 idle eos", irq, 0);
    brd(4'd0, d); chk("R8 idle eos index", d, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule